// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a small processor core from normal execution into a trap or interrupt handler. While the core sits between instructions, the block looks at four possible causes: a bus-fault strobe, a break-trap strobe, a non-maskable interrupt level and a maskable interrupt level. It decides which one may be taken, copies the core's architectural context, and works out the new register values. It then reads the handler address from a vector table through a single-word read port and hands the new program counter back with a one-cycle completion pulse.

The core writes the offered values into its own register file when the pulse arrives. The values are the return address, the exception status word, the rewritten status register and the swapped stack pointers. The core also zeroes its delay-slot count at that moment. The sequence runs in four states in order: idle, capture, vector read (which waits for read data) and done. Break and bus-fault strobes are latched, so a strobe that arrives while another entry is running is not lost. A second bus fault while one is still pending is flagged as fatal.

Top module: `exc_entry_seq`

## Requirements
- R1: A maskable interrupt is taken only when `irq_req` is high, status bit 5 (interrupt enable) is set and `irq_locked` is low. Otherwise the request is ignored and `busy` stays low.
- R2: A non-maskable interrupt is taken only when its mask bit in the status word is set. That bit is bit 7 when `ver_i` is below 32 and bit 30 for any other version. The other bit has no effect.
- R3: When several causes are eligible in the same idle cycle, the order is bus fault first, then break, then non-maskable interrupt, then maskable interrupt. Causes not chosen are served in later entries.
- R4: A non-maskable entry uses vector 0. It asserts `nrp_we` and not `erp_we`, and the mask bit it tested is cleared before the status rewrite of R9.
- R5: `cause_o` reports 0 for a maskable interrupt, 1 for a non-maskable interrupt, 2 for a break and 3 for a bus fault. A break uses `trap_vec`, a bus fault uses `fault_vec` and a maskable interrupt uses `irq_vec`. These three assert `erp_we` and not `nrp_we`.
- R6: `exs_o` carries the low 8 bits of the vector in bits 15:8 and zero in every other bit.
- R7: The return address on `erp_o` / `nrp_o` is the captured PC minus the captured delay-slot count.
- R8: When status bit 8 (user mode) is set, `stk_swap` is high, `usp_o` equals the old stack pointer and `sp_o` equals `ksp_i`. Otherwise `stk_swap` is low and `sp_o` equals the old stack pointer.
- R9: `ccs_o` keeps bits 31:30 of the status word, places old bits 19:0 at bits 29:10, and clears bits 9:0. Clearing the low bits also leaves user mode.
- R10: The read address is `ebp_i + 4*vector`. `rd_req` stays high with a steady address until `rd_valid` is seen, and the returned `rd_data` becomes `new_pc`.
- R11: After reset, `busy`, `done`, `rd_req` and `fatal` are low. `done` is a one-cycle pulse in the cycle after `rd_valid` is accepted, and there is exactly one pulse per entry.
- R12: `brk_req` and `bus_fault_req` are single-cycle strobes. They are latched until the entry they cause completes.
- R13: A bus-fault strobe that arrives while a bus fault is still pending raises `fatal`, which stays high until reset. A bus-fault strobe that arrives after the previous bus-fault entry has completed does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Maskable interrupt request level |
| irq_locked | input | 1 | Maskable interrupts locked out |
| nmi_req | input | 1 | Non-maskable interrupt request level |
| brk_req | input | 1 | Break-trap strobe |
| bus_fault_req | input | 1 | Bus-fault strobe |
| trap_vec | input | VEC_W | Vector for break traps |
| fault_vec | input | VEC_W | Vector for bus faults |
| irq_vec | input | VEC_W | Vector from the interrupt controller |
| pc_i | input | XLEN | Current program counter |
| dslot_i | input | DSLOT_W | Pending delay-slot count |
| ccs_i | input | XLEN | Condition/status word |
| sp_i | input | XLEN | Current stack pointer |
| ksp_i | input | XLEN | Kernel stack pointer |
| ebp_i | input | XLEN | Vector table base |
| ver_i | input | VER_W | Core version number |
| rd_req | output | 1 | Vector-table read request |
| rd_addr | output | XLEN | Vector-table read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | XLEN | Read data (handler address) |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cause_o | output | 2 | Cause being served |
| new_pc | output | XLEN | Handler address |
| erp_o | output | XLEN | Return address for exception return register |
| erp_we | output | 1 | Write strobe for exception return register |
| nrp_o | output | XLEN | Return address for NMI return register |
| nrp_we | output | 1 | Write strobe for NMI return register |
| exs_o | output | XLEN | New exception status word |
| ccs_o | output | XLEN | New status word |
| sp_o | output | XLEN | New stack pointer |
| usp_o | output | XLEN | Saved user stack pointer |
| stk_swap | output | 1 | Stack swap performed (user pointer valid) |
| fatal | output | 1 | Recursive bus fault detected (sticky) |

## Verification
The bench builds the block with its defaults: 32-bit data, 8-bit vectors, a 2-bit delay-slot count, dual mask-bit selection and a version split of 32. With those values it can drive versions on both sides of the split and so test both mask-bit positions. It can also use delay-slot counts from 0 to 3 and vectors whose high bits land in the address and status calculations. A variable read latency holds the vector read open long enough to inject a second bus fault mid-entry, and simultaneous requests show the service order.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   // Cause codes, as reported on cause_o
   typedef enum logic [1:0] {
      CS_IRQ  = 2'd0,
      CS_NMI  = 2'd1,
      CS_BRK  = 2'd2,
      CS_BUSF = 2'd3
   } exc_cause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SAVE  = 2'd1,
      ST_VREAD = 2'd2,
      ST_DONE  = 2'd3
   } seq_state_e;

endpackage

// File: rtl/exc_accept.sv
module exc_accept
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VEC_W     = 8,
   parameter int VER_W     = 8,
   parameter int I_BIT     = 5,
   parameter int M_BIT_OLD = 7,
   parameter int M_BIT_NEW = 30,
   parameter int VER_SPLIT = 32,
   parameter bit DUAL_M    = 1'b1
) (
   input  logic             irq_req,
   input  logic             irq_locked,
   input  logic             nmi_req,
   input  logic             brk_eff,
   input  logic             bf_eff,
   input  logic [XLEN-1:0]  ccs,
   input  logic [VER_W-1:0] ver,
   input  logic [VEC_W-1:0] trap_vec,
   input  logic [VEC_W-1:0] fault_vec,
   input  logic [VEC_W-1:0] irq_vec,
   output logic             take,
   output logic             nmi_ok,
   output exc_cause_e       cause,
   output logic [VEC_W-1:0] vec,
   output logic [XLEN-1:0]  m_mask
);

   localparam logic [XLEN-1:0] OLD_MASK = XLEN'(1) << M_BIT_OLD;
   localparam logic [XLEN-1:0] NEW_MASK = XLEN'(1) << M_BIT_NEW;

   logic irq_ok;

   generate
      if (DUAL_M) begin : g_dual_m
         always_comb m_mask = (int'({1'b0, ver}) < VER_SPLIT) ? OLD_MASK : NEW_MASK;
      end else begin : g_single_m
         assign m_mask = NEW_MASK;
      end
   endgenerate

   assign nmi_ok = nmi_req & (|(ccs & m_mask));
   assign irq_ok = irq_req & ccs[I_BIT] & ~irq_locked;
   assign take   = bf_eff | brk_eff | nmi_ok | irq_ok;

   always_comb begin
      cause = CS_IRQ;
      vec   = irq_vec;
      if (bf_eff) begin
         cause = CS_BUSF;
         vec   = fault_vec;
      end else if (brk_eff) begin
         cause = CS_BRK;
         vec   = trap_vec;
      end else if (nmi_ok) begin
         cause = CS_NMI;
         vec   = '0;
      end
   end

   // R1
   always_comb begin
      if (take && cause == CS_IRQ) begin
         irq_gate_chk: assert (ccs[I_BIT] && !irq_locked && irq_req);
      end
   end

endmodule

// File: rtl/exc_ctx_calc.sv
module exc_ctx_calc
   import exc_entry_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int VEC_W   = 8,
   parameter int DSLOT_W = 2,
   parameter int U_BIT   = 8
) (
   input  exc_cause_e         cause,
   input  logic [VEC_W-1:0]   vec,
   input  logic [XLEN-1:0]    pc,
   input  logic [DSLOT_W-1:0] dslot,
   input  logic [XLEN-1:0]    ccs,
   input  logic [XLEN-1:0]    sp,
   input  logic [XLEN-1:0]    ksp,
   input  logic [XLEN-1:0]    ebp,
   input  logic [XLEN-1:0]    m_mask,
   output logic [XLEN-1:0]    ret_addr,
   output logic [XLEN-1:0]    exs,
   output logic [XLEN-1:0]    ccs_new,
   output logic [XLEN-1:0]    sp_new,
   output logic [XLEN-1:0]    usp_new,
   output logic               swap,
   output logic [XLEN-1:0]    vaddr
);

   localparam int HIST_SH = 10;
   localparam int KEEP_HI = 2;

   logic [XLEN-1:0] ccs_m;

   assign ccs_m    = (cause == CS_NMI) ? (ccs & ~m_mask) : ccs;
   assign ccs_new  = {ccs_m[XLEN-1 -: KEEP_HI], ccs_m[XLEN-KEEP_HI-HIST_SH-1:0], {HIST_SH{1'b0}}};
   assign ret_addr = pc - XLEN'(dslot);
   assign exs      = {{(XLEN-16){1'b0}}, vec[7:0], 8'h00};
   assign swap     = ccs[U_BIT];
   assign sp_new   = swap ? ksp : sp;
   assign usp_new  = sp;
   assign vaddr    = ebp + (XLEN'(vec) << 2);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VEC_W     = 8,
   parameter int DSLOT_W   = 2,
   parameter int VER_W     = 8,
   parameter int I_BIT     = 5,
   parameter int U_BIT     = 8,
   parameter int M_BIT_OLD = 7,
   parameter int M_BIT_NEW = 30,
   parameter int VER_SPLIT = 32,
   parameter bit DUAL_M    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               irq_req,
   input  logic               irq_locked,
   input  logic               nmi_req,
   input  logic               brk_req,
   input  logic               bus_fault_req,
   input  logic [VEC_W-1:0]   trap_vec,
   input  logic [VEC_W-1:0]   fault_vec,
   input  logic [VEC_W-1:0]   irq_vec,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [DSLOT_W-1:0] dslot_i,
   input  logic [XLEN-1:0]    ccs_i,
   input  logic [XLEN-1:0]    sp_i,
   input  logic [XLEN-1:0]    ksp_i,
   input  logic [XLEN-1:0]    ebp_i,
   input  logic [VER_W-1:0]   ver_i,
   output logic               rd_req,
   output logic [XLEN-1:0]    rd_addr,
   input  logic               rd_valid,
   input  logic [XLEN-1:0]    rd_data,
   output logic               busy,
   output logic               done,
   output logic [1:0]         cause_o,
   output logic [XLEN-1:0]    new_pc,
   output logic [XLEN-1:0]    erp_o,
   output logic               erp_we,
   output logic [XLEN-1:0]    nrp_o,
   output logic               nrp_we,
   output logic [XLEN-1:0]    exs_o,
   output logic [XLEN-1:0]    ccs_o,
   output logic [XLEN-1:0]    sp_o,
   output logic [XLEN-1:0]    usp_o,
   output logic               stk_swap,
   output logic               fatal
);

   // elaboration-time parameter checks
   if (XLEN < 32) begin : g_bad_xlen
      $error("exc_entry_seq: XLEN must be at least 32");
   end
   if (VEC_W < 8 || VEC_W > XLEN - 2) begin : g_bad_vec
      $error("exc_entry_seq: VEC_W out of range");
   end
   if (U_BIT > 9 || I_BIT >= XLEN || M_BIT_OLD >= XLEN || M_BIT_NEW >= XLEN) begin : g_bad_bits
      $error("exc_entry_seq: flag bit position out of range");
   end
   if (DSLOT_W < 1 || DSLOT_W >= XLEN) begin : g_bad_ds
      $error("exc_entry_seq: DSLOT_W out of range");
   end

   seq_state_e         state_q, state_d;
   exc_cause_e         cause_q, acc_cause;
   logic [VEC_W-1:0]   vec_q, acc_vec;
   logic [XLEN-1:0]    pc_q, ccs_q, sp_q, ksp_q, ebp_q, mmask_q, acc_mmask, newpc_q;
   logic [DSLOT_W-1:0] dslot_q;
   logic               brk_pend_q, bf_pend_q, fatal_q;
   logic               acc_take, acc_nmi_ok, brk_eff, bf_eff, leave_rd;
   logic [XLEN-1:0]    ret_addr, vaddr;

   assign brk_eff  = brk_pend_q | brk_req;
   assign bf_eff   = bf_pend_q | bus_fault_req;
   assign leave_rd = (state_q == ST_VREAD) && rd_valid;

   exc_accept #(
      .XLEN(XLEN), .VEC_W(VEC_W), .VER_W(VER_W), .I_BIT(I_BIT),
      .M_BIT_OLD(M_BIT_OLD), .M_BIT_NEW(M_BIT_NEW),
      .VER_SPLIT(VER_SPLIT), .DUAL_M(DUAL_M)
   ) u_accept (
      .irq_req   (irq_req),
      .irq_locked(irq_locked),
      .nmi_req   (nmi_req),
      .brk_eff   (brk_eff),
      .bf_eff    (bf_eff),
      .ccs       (ccs_i),
      .ver       (ver_i),
      .trap_vec  (trap_vec),
      .fault_vec (fault_vec),
      .irq_vec   (irq_vec),
      .take      (acc_take),
      .nmi_ok    (acc_nmi_ok),
      .cause     (acc_cause),
      .vec       (acc_vec),
      .m_mask    (acc_mmask)
   );

   exc_ctx_calc #(
      .XLEN(XLEN), .VEC_W(VEC_W), .DSLOT_W(DSLOT_W), .U_BIT(U_BIT)
   ) u_ctx (
      .cause   (cause_q),
      .vec     (vec_q),
      .pc      (pc_q),
      .dslot   (dslot_q),
      .ccs     (ccs_q),
      .sp      (sp_q),
      .ksp     (ksp_q),
      .ebp     (ebp_q),
      .m_mask  (mmask_q),
      .ret_addr(ret_addr),
      .exs     (exs_o),
      .ccs_new (ccs_o),
      .sp_new  (sp_o),
      .usp_new (usp_o),
      .swap    (stk_swap),
      .vaddr   (vaddr)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (acc_take) state_d = ST_SAVE;
         ST_SAVE:  state_d = ST_VREAD;
         ST_VREAD: if (rd_valid) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cause_q    <= CS_IRQ;
         vec_q      <= '0;
         pc_q       <= '0;
         dslot_q    <= '0;
         ccs_q      <= '0;
         sp_q       <= '0;
         ksp_q      <= '0;
         ebp_q      <= '0;
         mmask_q    <= '0;
         newpc_q    <= '0;
         brk_pend_q <= 1'b0;
         bf_pend_q  <= 1'b0;
         fatal_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && acc_take) begin
            cause_q <= acc_cause;
            vec_q   <= acc_vec;
            pc_q    <= pc_i;
            dslot_q <= dslot_i;
            ccs_q   <= ccs_i;
            sp_q    <= sp_i;
            ksp_q   <= ksp_i;
            ebp_q   <= ebp_i;
            mmask_q <= acc_mmask;
         end
         if (leave_rd) newpc_q <= rd_data;
         brk_pend_q <= brk_eff & ~(leave_rd && cause_q == CS_BRK);
         bf_pend_q  <= bf_eff  & ~(leave_rd && cause_q == CS_BUSF);
         fatal_q    <= fatal_q | (bus_fault_req & bf_pend_q);
      end
   end

   assign rd_req  = (state_q == ST_VREAD);
   assign rd_addr = vaddr;
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_DONE);
   assign cause_o = cause_q;
   assign new_pc  = newpc_q;
   assign erp_o   = ret_addr;
   assign nrp_o   = ret_addr;
   assign erp_we  = done && (cause_q != CS_NMI);
   assign nrp_we  = done && (cause_q == CS_NMI);
   assign fatal   = fatal_q;

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rd_req && rd_valid));

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

   // R13
   fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fatal |=> fatal);

   // R3
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && acc_nmi_ok && !brk_eff && !bf_eff) |=> (cause_o == 2'd1));

endmodule

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;

   typedef struct packed {
      logic [1:0]  cause;
      logic [31:0] pc;
      logic [31:0] ret;
      logic [31:0] exs;
      logic [31:0] ccs;
      logic [31:0] sp;
      logic [31:0] usp;
      logic        swap;
   } exp_t;

   logic        clk, rst_n;
   logic        irq_req, irq_locked, nmi_req, brk_req, bus_fault_req;
   logic [7:0]  trap_vec, fault_vec, irq_vec, ver_i;
   logic [31:0] pc_i, ccs_i, sp_i, ksp_i, ebp_i;
   logic [1:0]  dslot_i;
   logic        rd_req, rd_valid;
   logic [31:0] rd_addr, rd_data;
   logic        busy, done, erp_we, nrp_we, stk_swap, fatal;
   logic [1:0]  cause_o;
   logic [31:0] new_pc, erp_o, nrp_o, exs_o, ccs_o, sp_o, usp_o;

   int   n_tests = 0;
   int   n_fail  = 0;
   int   rd_lat  = 0;
   exp_t exp_q[$];

   exc_entry_seq u0 (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_locked(irq_locked),
      .nmi_req(nmi_req), .brk_req(brk_req), .bus_fault_req(bus_fault_req),
      .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
      .pc_i(pc_i), .dslot_i(dslot_i), .ccs_i(ccs_i), .sp_i(sp_i), .ksp_i(ksp_i),
      .ebp_i(ebp_i), .ver_i(ver_i), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
      .cause_o(cause_o), .new_pc(new_pc), .erp_o(erp_o), .erp_we(erp_we),
      .nrp_o(nrp_o), .nrp_we(nrp_we), .exs_o(exs_o), .ccs_o(ccs_o),
      .sp_o(sp_o), .usp_o(usp_o), .stk_swap(stk_swap), .fatal(fatal)
   );

   initial begin
      clk = 1'b0;
      forever #4 clk = ~clk;
   end

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A5A, a[31:16]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // driver side: expected item from the current inputs
   task automatic push_exp(input logic [1:0] cause);
      exp_t        e;
      logic [7:0]  v;
      logic [31:0] c;
      int          mb;
      v  = (cause == 2'd0) ? irq_vec : (cause == 2'd1) ? 8'h00 :
           (cause == 2'd2) ? trap_vec : fault_vec;
      mb = (ver_i < 8'd32) ? 7 : 30;
      c  = ccs_i;
      if (cause == 2'd1) c[mb] = 1'b0;
      e.cause = cause;
      e.ccs   = {c[31:30], c[19:0], 10'b0};
      e.ret   = pc_i - {30'b0, dslot_i};
      e.exs   = {16'b0, v, 8'b0};
      e.swap  = ccs_i[8];
      e.sp    = ccs_i[8] ? ksp_i : sp_i;
      e.usp   = sp_i;
      e.pc    = mem_word(ebp_i + {22'b0, v, 2'b00});
      exp_q.push_back(e);
   endtask

   // memory responder for the vector read port
   initial begin
      int cnt;
      cnt      = 0;
      rd_valid = 1'b0;
      rd_data  = '0;
      forever begin
         @(negedge clk);
         if (rd_req && !rd_valid) begin
            if (cnt >= rd_lat) begin
               rd_valid = 1'b1;
               rd_data  = mem_word(rd_addr);
               cnt      = 0;
            end else begin
               cnt++;
            end
         end else begin
            rd_valid = 1'b0;
         end
      end
   end

   // monitor: pops expected items on each completion pulse
   initial begin
      bit   prev_done;
      exp_t e;
      prev_done = 1'b0;
      forever begin
         @(negedge clk);
         if (done && prev_done) chk(1'b0, "R11", "done longer than one cycle", 32'd1, 32'd0);
         if (done) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R11", "unexpected done", 32'd1, 32'd0);
            end else begin
               e = exp_q.pop_front();
               chk(cause_o == e.cause, "R5", "cause code", {30'b0, cause_o}, {30'b0, e.cause});
               chk(new_pc == e.pc, "R10", "handler address", new_pc, e.pc);
               chk(exs_o == e.exs, "R6", "exception status", exs_o, e.exs);
               chk(ccs_o == e.ccs, "R9", "status rewrite", ccs_o, e.ccs);
               chk(stk_swap == e.swap, "R8", "swap flag", {31'b0, stk_swap}, {31'b0, e.swap});
               chk(sp_o == e.sp, "R8", "stack pointer", sp_o, e.sp);
               if (e.swap) chk(usp_o == e.usp, "R8", "user stack pointer", usp_o, e.usp);
               if (e.cause == 2'd1) begin
                  chk(nrp_we && !erp_we, "R4", "nmi return strobe", {30'b0, nrp_we, erp_we}, 32'h2);
                  chk(nrp_o == e.ret, "R7", "nmi return address", nrp_o, e.ret);
               end else begin
                  chk(erp_we && !nrp_we, "R5", "return strobe", {30'b0, nrp_we, erp_we}, 32'h1);
                  chk(erp_o == e.ret, "R7", "return address", erp_o, e.ret);
               end
            end
         end
         prev_done = done;
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic expect_idle(input string req, input string what, input int n);
      bit seen;
      seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (busy) seen = 1'b1;
      end
      chk(!seen, req, what, {31'b0, seen}, 32'd0);
   endtask

   task automatic strobe_brk();
      brk_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0;
   endtask

   task automatic strobe_bf();
      bus_fault_req = 1'b1;
      @(negedge clk);
      bus_fault_req = 1'b0;
   endtask

   task automatic wait_busy();
      while (!busy) @(negedge clk);
   endtask

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; irq_req = 0; irq_locked = 0; nmi_req = 0; brk_req = 0; bus_fault_req = 0;
      trap_vec = 8'h05; fault_vec = 8'h3F; irq_vec = 8'h2C; ver_i = 8'd40;
      pc_i = 32'h1000_0100; dslot_i = 0; ccs_i = 32'h8003_F0A4;
      sp_i = 32'h7FFF_0000; ksp_i = 32'h0000_8000; ebp_i = 32'h0000_4000;
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(!busy && !done && !rd_req && !fatal, "R11", "reset outputs",
          {28'b0, busy, done, rd_req, fatal}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: basic maskable entry
      push_exp(2'd0);
      irq_req = 1'b1; wait_busy(); irq_req = 1'b0;
      drain();

      // R1: enable clear, then locked -> ignored
      ccs_i = 32'h8003_F084; irq_req = 1'b1;
      expect_idle("R1", "irq with enable clear", 8);
      ccs_i = 32'h8003_F0A4; irq_locked = 1'b1;
      expect_idle("R1", "irq while locked", 8);
      irq_req = 1'b0; irq_locked = 1'b0;
      @(negedge clk);

      // R2 R4 R7 R8: NMI on new mask bit, user mode, delay slot 2
      ver_i = 8'd40; ccs_i = 32'h4000_0120; dslot_i = 2'd2; pc_i = 32'h2000_0040;
      push_exp(2'd1);
      nmi_req = 1'b1; wait_busy(); nmi_req = 1'b0;
      drain();

      // R2: old mask bit used below the version split
      ver_i = 8'd10; ccs_i = 32'h0001_0180; dslot_i = 2'd0;
      push_exp(2'd1);
      nmi_req = 1'b1; wait_busy(); nmi_req = 1'b0;
      drain();
      // R2: old bit has no effect at or above the split
      ver_i = 8'd40; nmi_req = 1'b1;
      expect_idle("R2", "nmi with only old mask bit", 8);
      nmi_req = 1'b0;
      @(negedge clk);

      // R12 R10: break strobe, delay slot 1, slow read
      ccs_i = 32'hC00F_FFFF; dslot_i = 2'd1; rd_lat = 3; pc_i = 32'h3000_1000;
      push_exp(2'd2);
      strobe_brk();
      drain();
      rd_lat = 0;

      // R3: NMI before maskable in the same cycle
      ccs_i = 32'h4000_0020; dslot_i = 2'd0; irq_vec = 8'h11;
      push_exp(2'd1); push_exp(2'd0);
      nmi_req = 1'b1; irq_req = 1'b1;
      wait_busy(); nmi_req = 1'b0;
      wait_done(); wait_busy(); irq_req = 1'b0;
      drain();

      // R3: break before NMI
      push_exp(2'd2); push_exp(2'd1);
      nmi_req = 1'b1; strobe_brk();
      wait_done(); wait_busy(); nmi_req = 1'b0;
      drain();

      // R3: bus fault before break
      push_exp(2'd3); push_exp(2'd2);
      brk_req = 1'b1; bus_fault_req = 1'b1;
      @(negedge clk);
      brk_req = 1'b0; bus_fault_req = 1'b0;
      drain();

      // R13: bus fault after completed bus fault is not fatal
      dslot_i = 2'd3; rd_lat = 2;
      push_exp(2'd3);
      strobe_bf();
      drain();
      push_exp(2'd3);
      strobe_bf();
      drain();
      chk(!fatal, "R13", "fatal after serial bus faults", {31'b0, fatal}, 32'd0);

      // R13: second bus fault while one pending is fatal
      rd_lat = 6;
      push_exp(2'd3);
      strobe_bf();
      while (!rd_req) @(negedge clk);
      strobe_bf();
      drain();
      chk(fatal, "R13", "fatal on recursive bus fault", {31'b0, fatal}, 32'd1);
      expect_idle("R13", "pending cleared after entry", 6);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule